// File: doc/BRIEF.md
# Dual-Enable Latched Bidirectional Transceiver

The block carries data between two 16-bit sides, A and B. The sides are split into two independent 8-bit groups. Each group has a path from A to B and a path from B to A. Each path has its own transparent latch and its own output driver. Each path takes three active-low controls: a path enable, a latch enable and an output enable. While the path enable and the latch enable are both low, the latch is transparent. When either of them goes high, the latch closes and keeps what it last sampled. The output of a path drives only when its path enable and its output enable are both low.

Each side is modelled as separate vectors: an input vector, an output vector, and one output-enable bit per group. A pad ring outside the block builds the real three-state pads from these. The latch is a register clocked by `clk`. It samples every cycle while it is transparent. While transparent, the output passes the input through without a clock delay. The controls are level-sensitive pins, not a stream, so there is no valid/ready handshake and no back-pressure.

Top module: `xcvr_dual_latch`

## Requirements
- R1: While a path's enable and latch enable are both low, the latch is transparent, and a driving output equals the path's input in the same cycle.
- R2: When the latch enable goes high while the path enable stays low, the output keeps the input value sampled at the last clock edge at which the latch was still transparent.
- R3: When the path enable goes high while the latch enable is low, the latch stores the same last-sampled value. When the path enable returns low with the latch enable high, the output shows that stored value.
- R4: A path's output-enable bit is 1 exactly when its path enable and its output enable are both low and reset is released. The output then shows the latch contents, or the input while transparent.
- R5: While the path enable or the output enable is high, the path's output-enable bit is 0 and its data output is all zeros.
- R6: With the output enable high, the latch still loads while its path enable and latch enable are low. Enabling the output afterwards shows the loaded value.
- R7: With the latch enable high, changes on the path's input have no effect on a driving output.
- R8: The two groups are independent. Controls of group 1 (side bits 15..8) do not affect group 0 (side bits 7..0), and controls of group 0 do not affect group 1.
- R9: The B-to-A paths behave as R1 to R7 do, using their own three controls. Their data goes from `b_in` to `a_out` and their enable bits come out on `a_oe`.
- R10: While `rst_n` is low, every output-enable bit is 0 and every data output is zero. After reset, every latch holds zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the latch registers |
| rst_n | input | 1 | Active-low synchronous reset |
| a_in | input | 16 | Data arriving from side A |
| b_in | input | 16 | Data arriving from side B |
| en_ab_n | input | 2 | A-to-B path enable, one bit per group, active low |
| le_ab_n | input | 2 | A-to-B latch enable, one bit per group, active low |
| oe_ab_n | input | 2 | A-to-B output enable, one bit per group, active low |
| en_ba_n | input | 2 | B-to-A path enable, one bit per group, active low |
| le_ba_n | input | 2 | B-to-A latch enable, one bit per group, active low |
| oe_ba_n | input | 2 | B-to-A output enable, one bit per group, active low |
| b_out | output | 16 | Data driven toward side B |
| b_oe | output | 2 | Side-B driver enable, one bit per group |
| a_out | output | 16 | Data driven toward side A |
| a_oe | output | 2 | Side-A driver enable, one bit per group |

## Verification
Directed sequences take one path through each mode in turn: transparent, closed by the latch enable, closed by the path enable, loaded with the output off, and hold under changing data. This separates the two ways of closing the latch and shows which sampled value ends up stored. A sequence that toggles one group while the other is parked tells shared control apart from per-group control. A mirrored sequence on B-to-A catches a mix-up between the two directions. Seeded random control and data patterns then walk through every row of the function table on all four paths. These patterns include both directions of a group driving at once.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int GROUP_W  = 8;
  localparam int N_GROUPS = 2;
  localparam int BUS_W    = GROUP_W * N_GROUPS;
endpackage

// File: rtl/xcvr_latch_path.sv
module xcvr_latch_path #(
  parameter int GW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [GW-1:0] din,
  input  logic          en_n,
  input  logic          le_n,
  input  logic          oe_n,
  output logic [GW-1:0] dout,
  output logic          drive
);
  logic [GW-1:0] q;
  logic          transp;
  logic [GW-1:0] shown;

  assign transp = !en_n && !le_n;

  always_ff @(posedge clk) begin
    if (!rst_n)      q <= '0;
    else if (transp) q <= din;
  end

  assign drive = rst_n && !en_n && !oe_n;
  assign shown = transp ? din : q;
  assign dout  = drive ? shown : '0;

  AST_FOLLOW_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (transp && drive) |-> (dout == din)); // R1
  AST_CAPTURE_ON_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(transp) && !transp && drive) |-> (dout == $past(din))); // R2
  AST_HOLD_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(transp) && !transp && drive && $past(drive)) |-> $stable(dout)); // R7
  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (en_n || oe_n) |-> (!drive && dout == '0)); // R5
  always_comb begin
    if (!rst_n) AST_RESET_QUIET: assert (!drive && dout == '0); // R10
  end
endmodule

// File: rtl/xcvr_group.sv
module xcvr_group #(
  parameter int GW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [GW-1:0] a_in,
  input  logic [GW-1:0] b_in,
  input  logic          en_ab_n,
  input  logic          le_ab_n,
  input  logic          oe_ab_n,
  input  logic          en_ba_n,
  input  logic          le_ba_n,
  input  logic          oe_ba_n,
  output logic [GW-1:0] b_out,
  output logic          b_oe,
  output logic [GW-1:0] a_out,
  output logic          a_oe
);
  xcvr_latch_path #(.GW(GW)) u_ab (
    .clk(clk), .rst_n(rst_n), .din(a_in),
    .en_n(en_ab_n), .le_n(le_ab_n), .oe_n(oe_ab_n),
    .dout(b_out), .drive(b_oe)
  );

  xcvr_latch_path #(.GW(GW)) u_ba (
    .clk(clk), .rst_n(rst_n), .din(b_in),
    .en_n(en_ba_n), .le_n(le_ba_n), .oe_n(oe_ba_n),
    .dout(a_out), .drive(a_oe)
  );
endmodule

// File: rtl/xcvr_dual_latch.sv
module xcvr_dual_latch
  import xcvr_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [BUS_W-1:0]    a_in,
  input  logic [BUS_W-1:0]    b_in,
  input  logic [N_GROUPS-1:0] en_ab_n,
  input  logic [N_GROUPS-1:0] le_ab_n,
  input  logic [N_GROUPS-1:0] oe_ab_n,
  input  logic [N_GROUPS-1:0] en_ba_n,
  input  logic [N_GROUPS-1:0] le_ba_n,
  input  logic [N_GROUPS-1:0] oe_ba_n,
  output logic [BUS_W-1:0]    b_out,
  output logic [N_GROUPS-1:0] b_oe,
  output logic [BUS_W-1:0]    a_out,
  output logic [N_GROUPS-1:0] a_oe
);
  for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
    xcvr_group #(.GW(GROUP_W)) u_grp (
      .clk(clk), .rst_n(rst_n),
      .a_in(a_in[g*GROUP_W +: GROUP_W]),
      .b_in(b_in[g*GROUP_W +: GROUP_W]),
      .en_ab_n(en_ab_n[g]), .le_ab_n(le_ab_n[g]), .oe_ab_n(oe_ab_n[g]),
      .en_ba_n(en_ba_n[g]), .le_ba_n(le_ba_n[g]), .oe_ba_n(oe_ba_n[g]),
      .b_out(b_out[g*GROUP_W +: GROUP_W]), .b_oe(b_oe[g]),
      .a_out(a_out[g*GROUP_W +: GROUP_W]), .a_oe(a_oe[g])
    );
  end
endmodule

// File: tb/sim_xcvr_dual_latch.sv
`timescale 1ns/1ps
module sim_xcvr_dual_latch;
  logic clk = 0;
  logic rst_n = 0;
  logic [15:0] a_in = 0, b_in = 0, a_out, b_out;
  logic [1:0] en_ab_n = 0, le_ab_n = 0, oe_ab_n = 0;
  logic [1:0] en_ba_n = 0, le_ba_n = 0, oe_ba_n = 0;
  logic [1:0] a_oe, b_oe;
  int checks = 0, errors = 0, overlaps = 0;
  logic [7:0] m_ab [2];
  logic [7:0] m_ba [2];
  bit done = 0;

  always #4 clk = ~clk;

  xcvr_dual_latch u0 (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
    .en_ab_n(en_ab_n), .le_ab_n(le_ab_n), .oe_ab_n(oe_ab_n),
    .en_ba_n(en_ba_n), .le_ba_n(le_ba_n), .oe_ba_n(oe_ba_n),
    .b_out(b_out), .b_oe(b_oe), .a_out(a_out), .a_oe(a_oe)
  );

  function automatic logic exp_drv(logic rst, logic en, logic oe);
    return rst && !en && !oe;
  endfunction

  function automatic logic [7:0] exp_dat(logic rst, logic [7:0] q, logic [7:0] d,
                                         logic en, logic le, logic oe);
    if (!exp_drv(rst, en, oe)) return 8'h00;
    return (!en && !le) ? d : q;
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag);
    #1;
    for (int g = 0; g < 2; g++) begin
      logic [7:0] eb, ea;
      logic db, da;
      eb = exp_dat(rst_n, m_ab[g], a_in[g*8 +: 8], en_ab_n[g], le_ab_n[g], oe_ab_n[g]);
      ea = exp_dat(rst_n, m_ba[g], b_in[g*8 +: 8], en_ba_n[g], le_ba_n[g], oe_ba_n[g]);
      db = exp_drv(rst_n, en_ab_n[g], oe_ab_n[g]);
      da = exp_drv(rst_n, en_ba_n[g], oe_ba_n[g]);
      check(b_out[g*8 +: 8] == eb, tag, $sformatf("b_out grp%0d", g), b_out[g*8 +: 8], eb);
      check(b_oe[g] == db, tag, $sformatf("b_oe grp%0d", g), b_oe[g], db);
      check(a_out[g*8 +: 8] == ea, tag, $sformatf("a_out grp%0d", g), a_out[g*8 +: 8], ea);
      check(a_oe[g] == da, tag, $sformatf("a_oe grp%0d", g), a_oe[g], da);
      if (a_oe[g] && b_oe[g]) overlaps++;
    end
    @(posedge clk);
    for (int g = 0; g < 2; g++) begin
      if (!rst_n) begin
        m_ab[g] = 8'h00;
        m_ba[g] = 8'h00;
      end else begin
        if (!en_ab_n[g] && !le_ab_n[g]) m_ab[g] = a_in[g*8 +: 8];
        if (!en_ba_n[g] && !le_ba_n[g]) m_ba[g] = b_in[g*8 +: 8];
      end
    end
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd1234));
    m_ab[0] = 0; m_ab[1] = 0; m_ba[0] = 0; m_ba[1] = 0;
    @(negedge clk);
    a_in = 16'hA5C3; b_in = 16'h3C5A;
    step("R10"); step("R10");
    rst_n = 1;
    en_ab_n = 2'b11; en_ba_n = 2'b11; le_ab_n = 2'b11; le_ba_n = 2'b11;
    oe_ab_n = 2'b11; oe_ba_n = 2'b11;
    step("R10");
    en_ab_n = 2'b00; oe_ab_n = 2'b00; en_ba_n = 2'b00; oe_ba_n = 2'b00;
    step("R10");
    // R1 transparent follow on group 0 A-to-B
    en_ba_n = 2'b11;
    le_ab_n[0] = 0; a_in[7:0] = 8'h11; step("R1");
    a_in[7:0] = 8'h22; step("R1");
    // R2 close by latch enable, then data change
    le_ab_n[0] = 1; a_in[7:0] = 8'h33; step("R2");
    a_in[7:0] = 8'h44; step("R7");
    a_in[7:0] = 8'h55; step("R7");
    // R3 close by path enable
    le_ab_n[0] = 0; step("R1");
    en_ab_n[0] = 1; a_in[7:0] = 8'h66; step("R3");
    le_ab_n[0] = 1; step("R5");
    en_ab_n[0] = 0; a_in[7:0] = 8'h77; step("R3");
    // R6 load while output off
    oe_ab_n[0] = 1; le_ab_n[0] = 0; a_in[7:0] = 8'h88; step("R6");
    le_ab_n[0] = 1; a_in[7:0] = 8'h99; step("R6");
    oe_ab_n[0] = 0; step("R6");
    // R8 group 1 parked closed while group 0 transparent moves
    le_ab_n[1] = 0; a_in[15:8] = 8'hB1; step("R8");
    le_ab_n[1] = 1; step("R8");
    le_ab_n[0] = 0;
    for (int i = 0; i < 4; i++) begin
      a_in = {8'(8'hC0 + i), 8'(8'h10 * i)};
      step("R8");
    end
    // R9 B-to-A mirrored on group 1
    en_ab_n = 2'b11; en_ba_n = 2'b00; oe_ba_n = 2'b00; le_ba_n = 2'b00;
    b_in = 16'hD200; step("R9");
    le_ba_n[1] = 1; b_in = 16'hE3F4; step("R9");
    en_ba_n[1] = 1; step("R9");
    en_ba_n[1] = 0; b_in = 16'h0101; step("R9");
    // random sweep over all function table rows
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      a_in = r[15:0]; b_in = r[31:16];
      r = $urandom;
      en_ab_n = (r[1:0] == 0) ? 2'b11 : r[3:2] & r[5:4];
      en_ba_n = (r[7:6] == 0) ? 2'b11 : r[9:8] & r[11:10];
      le_ab_n = r[13:12]; le_ba_n = r[15:14];
      oe_ab_n = r[17:16] & r[19:18]; oe_ba_n = r[21:20] & r[23:22];
      if (r[31:28] == 0) rst_n = 0; else rst_n = 1;
      step("R4");
    end
    $display("both directions of a group drove together in %0d samples", overlaps);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog R4 actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule